// File: doc/BRIEF.md
# Magic-Packet Wake Controller

This block sits on the PHY side of an Ethernet link and wakes a sleeping host when a magic packet arrives. Software arms it through a small register port: it first sets an arm bit, then writes a 48-bit station address in three 16-bit pieces. The final address write loads the address, marks it valid and turns on magic-packet wake in one step. From then on the block watches a byte-wide receive stream, one frame at a time, for the wake pattern.

A magic packet is a run of at least six 0xFF bytes followed directly by sixteen back-to-back copies of the station address. It may start anywhere inside a frame. When one is seen, the block sets a sticky status bit, enters wake-active mode, raises a busy flag that holds off a management bus, and pulses a wake message toward the host controller. The message repeats on a fixed timeout until the host clears the wake-active bit or pulses the host reset input. While wake-active mode is in force, further magic packets change nothing.

Two state machines do the work. The matcher has the states M_IDLE (outside a frame), M_SYNC (counting 0xFF bytes), M_ADDR (comparing address copies) and M_HOLD (pattern found, waiting for frame end). Its transitions: a start marker goes to M_SYNC with an empty count; in M_SYNC a full 0xFF run followed by address byte 0 goes to M_ADDR; any mismatch in M_ADDR goes back to M_SYNC; the final byte of the sixteenth copy goes to M_HOLD; an end marker from any state goes to M_IDLE. The wake sequencer has the states W_IDLE, W_SEND (message cycle) and W_WAIT (timeout running). Its transitions: an enabled match goes W_IDLE to W_SEND; W_SEND always goes to W_WAIT; an expired timeout goes W_WAIT to W_SEND; a host clear or host reset goes from any state to W_IDLE.

Top module: `wol_wake_ctrl`

## Requirements
- R1: Writes to registers 27, 28 and 29 leave the station address, the valid flag and the enable bit unchanged while the arm bit (bit 10 of register 26) is 0.
- R2: With the arm bit set, register 27 holds address bytes 0 (bits 7:0) and 1 (bits 15:8), register 28 bytes 2 and 3, register 29 bytes 4 and 5; byte 0 is the first address byte on the wire; all three read back as written.
- R3: A write to register 29 with the arm bit set also sets the address-valid flag (bit 8 of register 30) and the wake-enable bit (bit 0 of register 26); writes to 27 and 28 do not.
- R4: Six or more consecutive 0xFF bytes followed by sixteen consecutive copies of the station address, anywhere after a frame's start marker, set the magic status bit (bit 0 of register 30) and the wake-active bit (bit 4 of register 31), and raise wake_msg for exactly one cycle starting at the first clock edge after the edge that accepts the last address byte.
- R5: A frame end marker before the pattern is complete, or a wrong byte among the address copies, produces no wake and no status.
- R6: While wake-active, wake_msg is pulsed again every RETX_CYCLES clock cycles after the previous pulse.
- R7: mgmt_busy is high exactly while wake-active mode is in force.
- R8: A magic packet received while wake-active changes neither the status nor the message schedule.
- R9: Writing register 31 with bit 4 at 0 ends wake-active mode and stops the messages; writing it with bit 4 at 1 has no effect.
- R10: The magic status bit stays set until software writes 1 to bit 0 of register 30, which clears it.
- R11: A magic packet causes no wake unless both the address-valid flag and the wake-enable bit are set; writing register 26 with bit 0 at 0 clears the enable bit.
- R12: A pulse on host_rst ends wake-active mode and the timeout but keeps the status bits.
- R13: After reset all registers read 0 and wake_msg and mgmt_busy are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register number for write and read |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_data | input | 8 | Receive byte |
| host_rst | input | 1 | Host reset of wake-active mode |
| wake_msg | output | 1 | Wake message pulse to the host controller |
| mgmt_busy | output | 1 | Management bus held off while wake-active |

## Verification
The hardest situation to reach is a second magic packet landing inside the wake-active window, where it must leave the running retransmit schedule untouched. The bench shortens the timeout to a few hundred cycles, sends a full frame, queues the expected message cycles derived from the cycle that accepted the last address byte, and then streams another complete magic frame between the first two messages. Any extra, missing or shifted message surfaces in the scoreboard, and aborted and corrupted frames are sent beforehand to show the matcher recovers without a false wake.

// File: rtl/wol_pkg.sv
package wol_pkg;
    localparam int MAC_BYTES = 6;
    localparam logic [7:0] SYNC_BYTE = 8'hFF;

    // Register numbers
    localparam int unsigned REG_CTRL = 26;
    localparam int unsigned REG_ADR0 = 27;
    localparam int unsigned REG_ADR1 = 28;
    localparam int unsigned REG_ADR2 = 29;
    localparam int unsigned REG_STAT = 30;
    localparam int unsigned REG_PORT = 31;

    // Field positions
    localparam int CTRL_ARM_BIT    = 10;
    localparam int CTRL_APME_BIT   = 0;
    localparam int STAT_MAGIC_BIT  = 0;
    localparam int STAT_VALID_BIT  = 8;
    localparam int PORT_ACTIVE_BIT = 4;

    typedef enum logic [1:0] {M_IDLE, M_SYNC, M_ADDR, M_HOLD} match_st_t;
    typedef enum logic [1:0] {W_IDLE, W_SEND, W_WAIT} wake_st_t;
endpackage

// File: rtl/wol_regs.sv
module wol_regs
    import wol_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [REG_AW-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    input  logic              capture,
    input  logic              wake_active,
    output logic              arm,
    output logic              apm_en,
    output logic              addr_valid,
    output logic              magic_st,
    output logic [47:0]       addr48,
    output logic              clr_active
);
    logic [31:0] addr_lo;
    logic [15:0] addr_hi;

    assign addr48 = {addr_hi, addr_lo};

    assign clr_active = wr && (addr == REG_AW'(REG_PORT)) && !wdata[PORT_ACTIVE_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm        <= 1'b0;
            apm_en     <= 1'b0;
            addr_valid <= 1'b0;
            magic_st   <= 1'b0;
            addr_lo    <= '0;
            addr_hi    <= '0;
        end else begin
            if (wr) begin
                unique case (addr)
                    REG_AW'(REG_CTRL): begin
                        arm    <= wdata[CTRL_ARM_BIT];
                        apm_en <= wdata[CTRL_APME_BIT];
                    end
                    REG_AW'(REG_ADR0): if (arm) addr_lo[15:0]  <= wdata;
                    REG_AW'(REG_ADR1): if (arm) addr_lo[31:16] <= wdata;
                    REG_AW'(REG_ADR2): if (arm) begin
                        addr_hi    <= wdata;
                        addr_valid <= 1'b1;
                        apm_en     <= 1'b1;
                    end
                    REG_AW'(REG_STAT): if (wdata[STAT_MAGIC_BIT]) magic_st <= 1'b0;
                    default: ;
                endcase
            end
            // a capture in the same cycle as a clear wins
            if (capture) magic_st <= 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            REG_AW'(REG_CTRL): begin
                rdata[CTRL_ARM_BIT]  = arm;
                rdata[CTRL_APME_BIT] = apm_en;
            end
            REG_AW'(REG_ADR0): rdata = addr_lo[15:0];
            REG_AW'(REG_ADR1): rdata = addr_lo[31:16];
            REG_AW'(REG_ADR2): rdata = addr_hi;
            REG_AW'(REG_STAT): begin
                rdata[STAT_MAGIC_BIT] = magic_st;
                rdata[STAT_VALID_BIT] = addr_valid;
            end
            REG_AW'(REG_PORT): rdata[PORT_ACTIVE_BIT] = wake_active;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/wol_matcher.sv
module wol_matcher
    import wol_pkg::*;
#(
    parameter int COPIES   = 16,
    parameter int SYNC_LEN = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic        rx_sof,
    input  logic        rx_eof,
    input  logic [7:0]  rx_data,
    input  logic [47:0] addr48,
    output logic        hit
);
    localparam int FF_W  = $clog2(SYNC_LEN + 1);
    localparam int IDX_W = $clog2(MAC_BYTES);
    localparam int REP_W = $clog2(COPIES);
    localparam logic [FF_W-1:0]  FF_FULL  = FF_W'(SYNC_LEN);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(MAC_BYTES - 1);
    localparam logic [REP_W-1:0] REP_LAST = REP_W'(COPIES - 1);

    match_st_t          st_q, st_n, cur;
    logic [FF_W-1:0]    ff_q, ff_n, cur_ff;
    logic [IDX_W-1:0]   idx_q, idx_n;
    logic [REP_W-1:0]   rep_q, rep_n;
    logic               hit_n;
    logic [7:0]         mac_b [MAC_BYTES];

    always_comb begin
        for (int k = 0; k < MAC_BYTES; k++) mac_b[k] = addr48[8*k +: 8];
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= M_IDLE;
            ff_q  <= '0;
            idx_q <= '0;
            rep_q <= '0;
        end else begin
            st_q  <= st_n;
            ff_q  <= ff_n;
            idx_q <= idx_n;
            rep_q <= rep_n;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hit <= 1'b0;
        else        hit <= hit_n;
    end

    always_comb begin
        st_n   = st_q;
        ff_n   = ff_q;
        idx_n  = idx_q;
        rep_n  = rep_q;
        hit_n  = 1'b0;
        cur    = st_q;
        cur_ff = ff_q;
        if (rx_valid) begin
            if (rx_sof) begin
                cur    = M_SYNC;
                cur_ff = '0;
            end
            st_n = cur;
            ff_n = cur_ff;
            unique case (cur)
                M_IDLE: ;
                M_SYNC: begin
                    if (rx_data == SYNC_BYTE) begin
                        if (cur_ff != FF_FULL) ff_n = cur_ff + FF_W'(1);
                    end else if (cur_ff == FF_FULL && rx_data == mac_b[0]) begin
                        st_n  = M_ADDR;
                        idx_n = IDX_W'(1);
                        rep_n = '0;
                        ff_n  = '0;
                    end else begin
                        ff_n = '0;
                    end
                end
                M_ADDR: begin
                    if (rx_data == mac_b[idx_q]) begin
                        if (idx_q == IDX_LAST) begin
                            idx_n = '0;
                            if (rep_q == REP_LAST) begin
                                hit_n = 1'b1;
                                st_n  = M_HOLD;
                            end else begin
                                rep_n = rep_q + REP_W'(1);
                            end
                        end else begin
                            idx_n = idx_q + IDX_W'(1);
                        end
                    end else begin
                        st_n = M_SYNC;
                        ff_n = (rx_data == SYNC_BYTE) ? FF_W'(1) : '0;
                    end
                end
                M_HOLD: ;
                default: st_n = M_IDLE;
            endcase
            if (rx_eof) st_n = M_IDLE;
        end
    end
endmodule

// File: rtl/wol_wake_fsm.sv
module wol_wake_fsm
    import wol_pkg::*;
#(
    parameter int RETX_CYCLES = 10_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic enable,
    input  logic host_clr,
    input  logic host_rst,
    output logic capture,
    output logic wake_msg,
    output logic active
);
    localparam int TW = $clog2(RETX_CYCLES);
    localparam logic [TW-1:0] T_LAST = TW'(RETX_CYCLES - 2);

    wake_st_t      st_q, st_n;
    logic [TW-1:0] tmr_q;

    assign capture = (st_q == W_IDLE) && hit && enable && !host_clr && !host_rst;

    always_comb begin
        st_n = st_q;
        if (host_rst || host_clr) begin
            st_n = W_IDLE;
        end else begin
            unique case (st_q)
                W_IDLE: if (capture) st_n = W_SEND;
                W_SEND: st_n = W_WAIT;
                W_WAIT: if (tmr_q == T_LAST) st_n = W_SEND;
                default: st_n = W_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= W_IDLE;
            tmr_q <= '0;
        end else begin
            st_q  <= st_n;
            tmr_q <= (st_q == W_WAIT && st_n == W_WAIT) ? tmr_q + TW'(1) : '0;
        end
    end

    // outputs
    always_comb begin
        wake_msg = (st_q == W_SEND);
        active   = (st_q != W_IDLE);
    end
endmodule

// File: rtl/wol_wake_ctrl.sv
module wol_wake_ctrl
    import wol_pkg::*;
#(
    parameter int REG_AW      = 5,
    parameter int RETX_CYCLES = 10_000_000,
    parameter int COPIES      = 16,
    parameter int SYNC_LEN    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic [7:0]        rx_data,
    input  logic              host_rst,
    output logic              wake_msg,
    output logic              mgmt_busy
);
    logic        arm, apm_en, addr_valid, magic_st;
    logic [47:0] addr48;
    logic        clr_active, capture, hit, wake_active;

    wol_regs #(.REG_AW(REG_AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
        .capture(capture), .wake_active(wake_active),
        .arm(arm), .apm_en(apm_en), .addr_valid(addr_valid), .magic_st(magic_st),
        .addr48(addr48), .clr_active(clr_active)
    );

    wol_matcher #(.COPIES(COPIES), .SYNC_LEN(SYNC_LEN)) u_match (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data),
        .addr48(addr48), .hit(hit)
    );

    wol_wake_fsm #(.RETX_CYCLES(RETX_CYCLES)) u_wake (
        .clk(clk), .rst_n(rst_n),
        .hit(hit), .enable(addr_valid && apm_en),
        .host_clr(clr_active), .host_rst(host_rst),
        .capture(capture), .wake_msg(wake_msg), .active(wake_active)
    );

    assign mgmt_busy = wake_active;
endmodule

// File: rtl/wol_wake_ctrl_chk.sv
module wol_wake_ctrl_chk
    import wol_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic              wdata0,
    input logic              host_rst,
    input logic              wake_msg,
    input logic              mgmt_busy,
    input logic              arm,
    input logic              apm_en,
    input logic              addr_valid,
    input logic              magic_st,
    input logic [47:0]       addr48
);
    logic adr_wr;
    assign adr_wr = reg_wr && (reg_addr == REG_AW'(REG_ADR0) ||
                               reg_addr == REG_AW'(REG_ADR1) ||
                               reg_addr == REG_AW'(REG_ADR2));

    // R1
    addr_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adr_wr && !arm) |=> $stable(addr48));

    // R3
    last_word_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && arm && reg_addr == REG_AW'(REG_ADR2)) |=> (addr_valid && apm_en));

    // R4
    msg_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_msg |=> !wake_msg);

    // R4
    wake_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mgmt_busy) |-> magic_st);

    // R7
    msg_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_msg |-> mgmt_busy);

    // R10
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (magic_st && !(reg_wr && reg_addr == REG_AW'(REG_STAT) && wdata0)) |=> magic_st);

    // R11
    wake_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mgmt_busy) |-> $past(addr_valid && apm_en));

    // R12
    host_rst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rst |=> !mgmt_busy);
endmodule

bind wol_wake_ctrl wol_wake_ctrl_chk #(.REG_AW(REG_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .wdata0(reg_wdata[0]), .host_rst(host_rst), .wake_msg(wake_msg),
    .mgmt_busy(mgmt_busy), .arm(arm), .apm_en(apm_en), .addr_valid(addr_valid),
    .magic_st(magic_st), .addr48(addr48)
);

// File: tb/wol_wake_ctrl_test.sv
`timescale 1ns/1ps
module wol_wake_ctrl_test;
    localparam int R = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        host_rst = 1'b0;
    logic        wake_msg, mgmt_busy;

    localparam logic [47:0] MAC = 48'hA6_95_84_73_62_02;

    int cyc = 0;
    int n_cmp = 0, n_bad = 0;
    int exp_q[$];
    bit done = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wol_wake_ctrl #(.RETX_CYCLES(R)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid),
        .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data), .host_rst(host_rst),
        .wake_msg(wake_msg), .mgmt_busy(mgmt_busy)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] a, input string tag, input logic [15:0] exp);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rxb(input logic [7:0] b, input logic s, input logic e);
        rx_valid = 1'b1; rx_data = b; rx_sof = s; rx_eof = e;
        @(posedge clk); #1;
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) begin @(posedge clk); #1; end
    endtask

    // junk prefix, 0xFF run, address copies (one byte optionally corrupted), trailer with end marker
    task automatic frame(input int pre, input int ff_run, input int copies,
                         input int bad_at, output int last);
        for (int i = 0; i < pre; i++) rxb(8'h10 + 8'(i), (i == 0), 1'b0);
        for (int i = 0; i < ff_run; i++) rxb(8'hFF, 1'b0, 1'b0);
        for (int c = 0; c < copies; c++) begin
            for (int b = 0; b < 6; b++) begin
                logic [7:0] v;
                v = MAC[8*b +: 8];
                if (c * 6 + b == bad_at) v = v ^ 8'h01;
                rxb(v, 1'b0, 1'b0);
            end
        end
        last = cyc;
        rxb(8'h33, 1'b0, 1'b1);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && wake_msg) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R6/R8: unexpected wake message at cycle %0d, expected none", cyc);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (e != cyc) begin
                    n_bad++;
                    $display("FAIL R4/R6: wake message at cycle %0d, expected %0d", cyc, e);
                end
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int last;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R13 reset state
        for (int a = 26; a <= 31; a++) rd(5'(a), "R13 reset register", 16'h0000);
        check("R13 wake_msg after reset", {15'b0, wake_msg}, 16'h0);
        check("R13 mgmt_busy after reset", {15'b0, mgmt_busy}, 16'h0);

        // R1 address writes ignored while unarmed
        wr(27, 16'h1234);
        wr(29, 16'hABCD);
        rd(27, "R1 reg27 unarmed", 16'h0000);
        rd(29, "R1 reg29 unarmed", 16'h0000);
        rd(30, "R1 valid unarmed", 16'h0000);
        rd(26, "R1 enable unarmed", 16'h0000);

        // R2 / R3 programming
        wr(26, 16'h0400);
        rd(26, "R3 arm only", 16'h0400);
        wr(27, MAC[15:0]);
        wr(28, MAC[31:16]);
        rd(26, "R3 no enable before reg29", 16'h0400);
        rd(30, "R3 no valid before reg29", 16'h0000);
        wr(29, MAC[47:32]);
        rd(26, "R3 enable set by reg29", 16'h0401);
        rd(30, "R3 valid set by reg29", 16'h0100);
        rd(27, "R2 reg27", MAC[15:0]);
        rd(28, "R2 reg28", MAC[31:16]);
        rd(29, "R2 reg29", MAC[47:32]);

        // R5 aborted frame (15 copies then end)
        frame(3, 6, 15, -1, last);
        repeat (5) @(posedge clk); #1;
        rd(30, "R5 abort status", 16'h0100);
        rd(31, "R5 abort active", 16'h0000);
        // R5 corrupted copy
        frame(2, 6, 16, 40, last);
        repeat (5) @(posedge clk); #1;
        rd(30, "R5 corrupt status", 16'h0100);
        rd(31, "R5 corrupt active", 16'h0000);

        // R4 / R6 / R7 valid magic packet with a longer 0xFF run
        frame(5, 8, 16, -1, last);
        for (int k = 0; k < 4; k++) exp_q.push_back(last + 1 + k * R);
        wait_until(last + 3);
        rd(30, "R4 status set", 16'h0101);
        rd(31, "R4 active set", 16'h0010);
        check("R7 busy while active", {15'b0, mgmt_busy}, 16'h1);

        // R8 second magic while active
        wait_until(last + 20);
        frame(1, 6, 16, -1, last);
        wait_until(exp_q[0] + 2);
        rd(30, "R8 status unchanged", 16'h0101);

        // R9 writing 1 has no effect
        wait_until(exp_q[1] + 10);
        wr(31, 16'h0010);
        rd(31, "R9 write 1 keeps active", 16'h0010);
        wait_until(exp_q[1] + 10);
        check("R6 all messages seen", 16'(exp_q.size()), 16'd0);
        wr(31, 16'h0000);
        rd(31, "R9 cleared", 16'h0000);
        check("R7 busy released", {15'b0, mgmt_busy}, 16'h0);
        rd(30, "R10 status kept after clear", 16'h0101);
        repeat (2 * R) @(posedge clk); #1;
        check("R9 no messages after clear", 16'(exp_q.size()), 16'd0);

        // R10 write-one-to-clear
        wr(30, 16'h0001);
        rd(30, "R10 status cleared", 16'h0100);

        // R11 enable cleared by software
        wr(26, 16'h0400);
        rd(26, "R11 enable cleared", 16'h0400);
        frame(2, 6, 16, -1, last);
        repeat (10) @(posedge clk); #1;
        rd(30, "R11 no status when disabled", 16'h0100);
        rd(31, "R11 no wake when disabled", 16'h0000);

        // R12 host reset
        wr(26, 16'h0401);
        frame(4, 7, 16, -1, last);
        exp_q.push_back(last + 1);
        wait_until(last + 5);
        host_rst = 1'b1;
        @(posedge clk); #1;
        host_rst = 1'b0;
        rd(31, "R12 active cleared", 16'h0000);
        check("R12 busy cleared", {15'b0, mgmt_busy}, 16'h0);
        rd(30, "R12 status kept", 16'h0101);
        repeat (2 * R) @(posedge clk); #1;
        check("R12 no retransmit after host reset", 16'(exp_q.size()), 16'd0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule